// File: doc/BRIEF.md
# Slot Interrupt Mask and Merge

This block merges interrupt requests from three mezzanine module slots into a single active-low, level-sensitive host interrupt. Each slot has two request lines, which gives six requests, and each request has its own enable bit. The request lines arrive asynchronously. Each line passes through a two-flop synchronizer, then through its enable gate, and the gated lines are combined.

A software force bit drives the host interrupt with no module fitted, which is useful when debugging the interrupt path. A bus-error source also feeds the merge. A one-cycle pulse from an external timeout detector sets a sticky flag. That flag is always visible in the status outputs. It reaches the interrupt only when its own enable bit is set. Software clears the flag by writing 1 to it, which arrives here as a clear strobe.

The enables, the force bit and the bus-error enable are held in an internal configuration register. A single write strobe loads all of these fields together. Address decoding and the host bus protocol are handled outside this block.

Top module: `slot_irq_merge`

## Requirements
- R1: While `rst_n` is low and after it rises, `irq_n_o` is 1, `stat_berr_o` is 0, `stat_req_o` is 0, and all enables, the force bit and the bus-error enable are 0. A request that arrives right after reset therefore does not assert the interrupt.
- R2: Request line index is `2*slot + k`, where slots A, B and C are slot numbers 0, 1 and 2, and k=0 selects INT0 and k=1 selects INT1. Enable bit i gates request line i.
- R3: When request i is high and enable bit i is set, `irq_n_o` goes low two rising edges after the request input changes. It returns high two edges after the request falls.
- R4: A request whose enable bit is 0 has no effect on `irq_n_o`.
- R5: `stat_req_o` shows each request line after the two-flop synchronizer, whatever its enable setting, two edges after the input changes.
- R6: While the force bit is 1, `irq_n_o` is 0 with no request present.
- R7: A one-cycle `berr_pulse_i` sets `stat_berr_o` on the next edge, whether or not the bus-error enable is set. The flag then stays set.
- R8: While the bus-error enable is 0, a set bus-error flag leaves `irq_n_o` high. While the enable is 1, the set flag drives `irq_n_o` low.
- R9: `berr_clr_i` clears the flag on the next edge. If a clear and a pulse arrive in the same cycle, the flag ends up set.
- R10: A configuration write with `cfg_we_i` high loads all three fields on one edge. While `cfg_we_i` is low, changes on the data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Raw module request lines, index 2*slot+k |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 6 | Enable bits to load, one per request |
| cfg_force_i | input | 1 | Force bit to load |
| cfg_berr_en_i | input | 1 | Bus-error interrupt enable to load |
| berr_pulse_i | input | 1 | One-cycle bus-error event from the detector |
| berr_clr_i | input | 1 | Write-1-to-clear strobe for the bus-error flag |
| irq_n_o | output | 1 | Host interrupt, active low |
| stat_req_o | output | 6 | Synchronized, unmasked request lines |
| stat_berr_o | output | 1 | Sticky bus-error flag |

## Verification
The assertions assume that the write strobe, the clear strobe and the bus-error pulse are synchronous to `clk`. They also assume that the bus-error pulse lasts one cycle, because the detector produces it that way. Only the request lines may be asynchronous. The bench drives every input on the falling edge, so each strobe is clean across exactly one rising edge. Each request is held for at least two edges so that the synchronized value settles before the bench samples it.

// File: rtl/slot_irq_merge.sv
module slot_irq_merge #(
  parameter int NSLOT = 3,
  parameter int NREQ  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT*NREQ-1:0]  req_i,
  input  logic                   cfg_we_i,
  input  logic [NSLOT*NREQ-1:0]  cfg_en_i,
  input  logic                   cfg_force_i,
  input  logic                   cfg_berr_en_i,
  input  logic                   berr_pulse_i,
  input  logic                   berr_clr_i,
  output logic                   irq_n_o,
  output logic [NSLOT*NREQ-1:0]  stat_req_o,
  output logic                   stat_berr_o
);
  localparam int NLINE = NSLOT * NREQ;

  logic [NLINE-1:0] meta_q, sync_q, en_q, hit;
  logic             force_q, berr_en_q, berr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= req_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      force_q   <= 1'b0;
      berr_en_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q      <= cfg_en_i;
      force_q   <= cfg_force_i;
      berr_en_q <= cfg_berr_en_i;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            berr_q <= 1'b0;
    else if (berr_pulse_i) berr_q <= 1'b1;
    else if (berr_clr_i)   berr_q <= 1'b0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar k = 0; k < NREQ; k++) begin : g_line
      assign hit[s*NREQ+k] = sync_q[s*NREQ+k] & en_q[s*NREQ+k];
    end
  end

  assign irq_n_o     = ~(|hit | force_q | (berr_q & berr_en_q));
  assign stat_req_o  = sync_q;
  assign stat_berr_o = berr_q;

  p_berr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse_i |=> stat_berr_o);

  p_berr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_clr_i && !berr_pulse_i) |=> !stat_berr_o);

  p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_force_i) |=> !irq_n_o);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> ($stable(en_q) && $stable(force_q) && $stable(berr_en_q)));

  p_sync_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_q == $past(meta_q)));
endmodule

// File: tb/test_slot_irq_merge.sv
module test_slot_irq_merge;
  localparam int NLINE = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [NLINE-1:0] req_i, cfg_en_i, stat_req_o;
  logic cfg_we_i, cfg_force_i, cfg_berr_en_i, berr_pulse_i, berr_clr_i;
  logic irq_n_o, stat_berr_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  slot_irq_merge i_slot_irq_merge (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_we_i(cfg_we_i),
    .cfg_en_i(cfg_en_i), .cfg_force_i(cfg_force_i), .cfg_berr_en_i(cfg_berr_en_i),
    .berr_pulse_i(berr_pulse_i), .berr_clr_i(berr_clr_i),
    .irq_n_o(irq_n_o), .stat_req_o(stat_req_o), .stat_berr_o(stat_berr_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [NLINE-1:0] en, input logic frc, input logic ben);
    cfg_en_i = en; cfg_force_i = frc; cfg_berr_en_i = ben; cfg_we_i = 1'b1;
    cycles(1);
    cfg_we_i = 1'b0; cfg_en_i = '0; cfg_force_i = 1'b0; cfg_berr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(irq_n_o, 1, "R1 irq in reset");
    chk(stat_berr_o, 0, "R1 berr in reset");
    rst_n = 1'b1;
    cycles(1);
    chk(stat_req_o, 0, "R1 status after reset");
    req_i = '1;
    cycles(2);
    chk(irq_n_o, 1, "R1 enables cleared");
    chk(stat_req_o, 6'h3f, "R5 raw status with no enables");
    req_i = '0;
    cycles(2);
  endtask

  task automatic t_map;
    for (int i = 0; i < NLINE; i++) begin
      cfg(6'(1 << i), 1'b0, 1'b0);
      req_i = 6'(1 << i);
      cycles(1);
      chk(irq_n_o, 1, "R3 one edge is not enough");
      cycles(1);
      chk(irq_n_o, 0, "R2 R3 enabled line asserts");
      chk(stat_req_o, 32'(1 << i), "R5 status position");
      req_i = 6'(1 << i) ^ '1;
      cycles(2);
      chk(irq_n_o, 1, "R4 other lines masked");
      req_i = '0;
      cycles(2);
      chk(irq_n_o, 1, "R3 release");
    end
  endtask

  task automatic t_slot_order;
    // slot B INT1 is index 3
    cfg(6'b001000, 1'b0, 1'b0);
    req_i = 6'b001000;
    cycles(2);
    chk(irq_n_o, 0, "R2 slot B INT1");
    req_i = 6'b000100;
    cycles(2);
    chk(irq_n_o, 1, "R2 slot B INT0 masked");
    req_i = '0;
    cycles(2);
  endtask

  task automatic t_force;
    cfg('0, 1'b1, 1'b0);
    chk(irq_n_o, 0, "R6 force");
    chk(stat_req_o, 0, "R6 no request present");
    cfg('0, 1'b0, 1'b0);
    chk(irq_n_o, 1, "R6 force off");
  endtask

  task automatic t_berr;
    berr_pulse_i = 1'b1;
    cycles(1);
    berr_pulse_i = 1'b0;
    chk(stat_berr_o, 1, "R7 flag set while masked");
    chk(irq_n_o, 1, "R8 masked berr");
    cycles(3);
    chk(stat_berr_o, 1, "R7 sticky");
    cfg('0, 1'b0, 1'b1);
    chk(irq_n_o, 0, "R8 enabled berr");
    berr_clr_i = 1'b1;
    cycles(1);
    berr_clr_i = 1'b0;
    chk(stat_berr_o, 0, "R9 cleared");
    chk(irq_n_o, 1, "R9 irq drops on clear");
    berr_pulse_i = 1'b1; berr_clr_i = 1'b1;
    cycles(1);
    berr_pulse_i = 1'b0; berr_clr_i = 1'b0;
    chk(stat_berr_o, 1, "R9 set wins");
    berr_clr_i = 1'b1;
    cycles(1);
    berr_clr_i = 1'b0;
    cfg('0, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    cfg(6'b100000, 1'b0, 1'b0);
    cfg_en_i = '1; cfg_force_i = 1'b1; cfg_berr_en_i = 1'b1;
    req_i = 6'b011111;
    cycles(2);
    chk(irq_n_o, 1, "R10 data ignored without strobe");
    req_i = 6'b100000;
    cycles(2);
    chk(irq_n_o, 0, "R10 earlier write kept");
    req_i = '0;
    cfg_en_i = '0; cfg_force_i = 1'b0; cfg_berr_en_i = 1'b0;
    cycles(2);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = '0; cfg_we_i = 1'b0; cfg_en_i = '0;
    cfg_force_i = 1'b0; cfg_berr_en_i = 1'b0; berr_pulse_i = 1'b0; berr_clr_i = 1'b0;
    cycles(3);
    t_reset;
    t_map;
    t_slot_order;
    t_force;
    t_berr;
    t_hold;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule